// File: doc/BRIEF.md
# Frame Sync Short-Packet Generator

This block turns the frame-valid level of a parallel video input into the frame-level short packets of a serial camera link. It samples frame-valid on the pixel clock and counts how long the level stays high. Only a high level that lasts for a programmable number of pixel clocks is taken as a real frame. A glitch that ends before the count reaches the threshold leaves no trace at the output. Once a frame has qualified, a frame-start packet is emitted. A frame-end packet follows when frame-valid drops.

The block has no knowledge of lines. A pulse that passes the threshold but carries no lines still produces a complete frame-start and frame-end pair. Each packet is a single 32-bit word. It holds a data identifier made of the port's virtual channel and a data type, a 16-bit frame number, and an error-correcting byte over those 24 bits. Short packets carry no payload checksum. Words leave through a one-deep output register with a valid/ready handshake. If the register cannot take a word, a pending frame event is held until the register frees up.

Top module: `fsp_frame_sync_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `pkt_valid` is 0.
- R2: The threshold is `cfg_min_time` + 5 pixel clocks, so a setting of 0 still needs 5 high samples. When frame-valid is sampled high on that many consecutive rising edges and the output register is empty, a frame-start word appears at the output. With `fv_in` driven high just after a clock edge, this happens after threshold + 1 edges.
- R3: A frame-valid pulse with fewer high samples than the threshold produces no packet. A single low sample restarts the count from zero, so two such pulses never add up.
- R4: Frame-start and frame-end words strictly alternate, and every qualified pulse yields exactly one of each. With `pkt_ready` held high, the frame-end word appears 2 edges after the first low sample of frame-valid. This holds even when the pulse contains no lines.
- R5: Word layout: bits [5:0] are the data type (0x00 frame-start, 0x01 frame-end). Bits [7:6] are the virtual channel, equal to parameter `VC_ID`. Bits [23:8] are the frame number. Bits [31:24] are the ECC byte, whose bits [31:30] are always 0.
- R6: ECC bit k is the XOR of the header bits i (bits [23:0] of the word) whose column code has bit k set. The codes for i = 0..23 are 07 0B 0D 0E 13 15 16 19 1A 1C 23 25 26 29 2A 2C 31 32 34 38 1F 2F 37 3B (hex).
- R7: The frame number is 1 for the first frame after reset. Frame-start and frame-end of one frame carry the same number. The number rises by 1 per frame and skips 0 on wrap.
- R8: While `pkt_valid` is 1 and `pkt_ready` is 0, `pkt_valid` and `pkt_data` hold their values. Frame-valid edges that arrive during such a stall are not lost: the held frame-start and frame-end are delivered once `pkt_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fv_in | input | 1 | Frame-valid level, synchronous to clk |
| cfg_min_time | input | CNT_W (8) | Extra qualification clocks added to the base of 5 |
| pkt_valid | output | 1 | Output word is valid |
| pkt_ready | input | 1 | Downstream accepts the word this cycle |
| pkt_data | output | 32 | Short-packet word |

## Verification
Pulses exactly at the threshold and one sample below it separate a correct "at least N samples" comparison from an off-by-one in either direction. Two sub-threshold pulses split by a single low sample show that the counter restarts rather than accumulates. Line-free frames at three threshold settings, under a pseudo-random ready pattern, compare every word against an independent model of layout, ECC and frame numbering. A long forced stall that spans both edges of a frame shows that the held word stays stable and that the postponed frame-end still arrives in order.

// File: rtl/fsp_pkg.sv
`timescale 1ns/1ps
// Package: shared types and constants for the frame sync short-packet generator.
// Assumes the 24-bit header is {frame number, virtual channel, data type}.
package fsp_pkg;

    localparam int HDR_W = 24;
    localparam int ECC_BITS = 6;

    typedef enum logic [5:0] {
        DT_FRAME_START = 6'h00,
        DT_FRAME_END   = 6'h01
    } sp_dtype_e;

    typedef struct packed {
        logic [7:0]  ecc;
        logic [15:0] fnum;
        logic [1:0]  vc;
        logic [5:0]  dt;
    } sp_word_t;

    // Parity selection masks over the header, one per ECC bit (index 0 = P0).
    localparam logic [ECC_BITS-1:0][HDR_W-1:0] ECC_MASKS = {
        24'hEFFC00,
        24'hDF03F0,
        24'hB8E38E,
        24'h749A6D,
        24'hF2555B,
        24'hF12CB7
    };

endpackage

// File: rtl/fsp_ecc.sv
`timescale 1ns/1ps
// Module: fsp_ecc
// Computes the 6-bit Hamming-style header ECC, zero-extended to a byte.
// Assumes a purely combinational use; the caller registers the result.
module fsp_ecc
    import fsp_pkg::*;
(
    input  logic [HDR_W-1:0] hdr,
    output logic [7:0]       ecc
);

    // One parity tree per ECC bit, selected by its mask.
    for (genvar k = 0; k < ECC_BITS; k++) begin : g_par
        assign ecc[k] = ^(hdr & ECC_MASKS[k]);
    end

    // Upper bits of the ECC byte are reserved and held at zero.
    assign ecc[7:ECC_BITS] = '0;

endmodule

// File: rtl/fsp_fv_qual.sv
`timescale 1ns/1ps
// Module: fsp_fv_qual
// Qualifies the frame-valid level and sequences frame-start / frame-end events.
// A frame qualifies after thr = cfg_min_time + MIN_BASE consecutive high samples.
// Each event is requested until acknowledged; a fall seen while frame-start is
// pending is remembered. Assumes fv is already synchronous to clk.
module fsp_fv_qual #(
    parameter int CNT_W    = 8,
    parameter int MIN_BASE = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fv,
    input  logic [CNT_W-1:0] cfg_min_time,
    input  logic             evt_ack,
    output logic             evt_req,
    output logic             evt_is_end,
    output logic [15:0]      fnum
);

    localparam int TH_W = CNT_W + 1;

    typedef enum logic [1:0] {
        Q_IDLE   = 2'd0,
        Q_FS_REQ = 2'd1,
        Q_ACTIVE = 2'd2,
        Q_FE_REQ = 2'd3
    } qstate_e;

    qstate_e         state_q;
    logic [TH_W-1:0] hi_cnt_q;
    logic [TH_W-1:0] thr;
    logic            fell_q;
    logic [15:0]     fnum_nxt;

    assign thr        = TH_W'(cfg_min_time) + TH_W'(MIN_BASE);
    assign evt_req    = (state_q == Q_FS_REQ) || (state_q == Q_FE_REQ);
    assign evt_is_end = (state_q == Q_FE_REQ);

    // Next frame number, skipping zero on wrap.
    always_comb begin
        fnum_nxt = fnum + 16'd1;
        if (fnum_nxt == 16'd0) begin
            fnum_nxt = 16'd1;
        end
    end

    // State, qualification counter, fall memory and frame number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= Q_IDLE;
            hi_cnt_q <= '0;
            fell_q   <= 1'b0;
            fnum     <= 16'd1;
        end else begin
            case (state_q)
                Q_IDLE: begin
                    if (!fv) begin
                        hi_cnt_q <= '0;
                    end else if (hi_cnt_q + TH_W'(1) >= thr) begin
                        hi_cnt_q <= '0;
                        state_q  <= Q_FS_REQ;
                    end else begin
                        hi_cnt_q <= hi_cnt_q + TH_W'(1);
                    end
                end
                Q_FS_REQ: begin
                    if (evt_ack) begin
                        state_q <= Q_ACTIVE;
                        fell_q  <= !fv;
                    end else if (!fv) begin
                        fell_q <= 1'b1;
                    end
                end
                Q_ACTIVE: begin
                    if (!fv || fell_q) begin
                        state_q <= Q_FE_REQ;
                        fell_q  <= 1'b0;
                    end
                end
                Q_FE_REQ: begin
                    if (evt_ack) begin
                        state_q  <= Q_IDLE;
                        hi_cnt_q <= '0;
                        fnum     <= fnum_nxt;
                    end
                end
                default: state_q <= Q_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fsp_out_reg.sv
`timescale 1ns/1ps
// Module: fsp_out_reg
// One-deep output holding register with a valid/ready handshake.
// A load is accepted when the register is empty or being emptied this cycle.
module fsp_out_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_req,
    input  logic [W-1:0] load_word,
    output logic         load_ack,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data
);

    assign load_ack = load_req && (!out_valid || out_ready);

    // Capture a new word or drop the valid flag once the word is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load_ack) begin
            out_valid <= 1'b1;
            out_data  <= load_word;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/fsp_frame_sync_gen.sv
`timescale 1ns/1ps
// Module: fsp_frame_sync_gen (top)
// Emits frame-start / frame-end short-packet words from a frame-valid level.
// Word = {ecc, frame number, VC_ID, data type}. Assumes fv_in is synchronous
// to clk and that VC_ID identifies the input port this instance serves.
module fsp_frame_sync_gen
    import fsp_pkg::*;
#(
    parameter int         CNT_W    = 8,
    parameter int         MIN_BASE = 5,
    parameter logic [1:0] VC_ID    = 2'd0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fv_in,
    input  logic [CNT_W-1:0] cfg_min_time,
    output logic             pkt_valid,
    input  logic             pkt_ready,
    output logic [31:0]      pkt_data
);

    logic        evt_req;
    logic        evt_is_end;
    logic        evt_ack;
    logic [15:0] fnum;
    logic [7:0]  ecc;
    sp_word_t    word;
    logic [HDR_W-1:0] hdr;

    fsp_fv_qual #(
        .CNT_W    (CNT_W),
        .MIN_BASE (MIN_BASE)
    ) u_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .fv           (fv_in),
        .cfg_min_time (cfg_min_time),
        .evt_ack      (evt_ack),
        .evt_req      (evt_req),
        .evt_is_end   (evt_is_end),
        .fnum         (fnum)
    );

    // Header assembly for the pending event.
    always_comb begin
        word.dt   = evt_is_end ? DT_FRAME_END : DT_FRAME_START;
        word.vc   = VC_ID;
        word.fnum = fnum;
        word.ecc  = ecc;
    end

    assign hdr = {word.fnum, word.vc, word.dt};

    fsp_ecc u_ecc (
        .hdr (hdr),
        .ecc (ecc)
    );

    fsp_out_reg #(
        .W (32)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_req  (evt_req),
        .load_word (word),
        .load_ack  (evt_ack),
        .out_ready (pkt_ready),
        .out_valid (pkt_valid),
        .out_data  (pkt_data)
    );

endmodule

// File: rtl/fsp_frame_sync_gen_chk.sv
`timescale 1ns/1ps
// Module: fsp_frame_sync_gen_chk
// Protocol checker bound to the top: word layout, ECC, alternation, numbering, stall hold.
module fsp_frame_sync_gen_chk #(
    parameter logic [1:0] VC_ID = 2'd0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        pkt_valid,
    input logic        pkt_ready,
    input logic [31:0] pkt_data
);

    localparam logic [5:0] COL [24] = '{
        6'h07, 6'h0B, 6'h0D, 6'h0E, 6'h13, 6'h15, 6'h16, 6'h19,
        6'h1A, 6'h1C, 6'h23, 6'h25, 6'h26, 6'h29, 6'h2A, 6'h2C,
        6'h31, 6'h32, 6'h34, 6'h38, 6'h1F, 6'h2F, 6'h37, 6'h3B
    };

    function automatic logic [7:0] col_ecc(input logic [23:0] h);
        logic [5:0] s;
        s = '0;
        for (int i = 0; i < 24; i++) begin
            if (h[i]) s = s ^ COL[i];
        end
        return {2'b00, s};
    endfunction

    logic        want_end_q;
    logic [15:0] open_fnum_q;

    // Track which packet kind is due next and the open frame's number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want_end_q  <= 1'b0;
            open_fnum_q <= '0;
        end else if (pkt_valid && pkt_ready) begin
            want_end_q <= !pkt_data[0];
            if (!pkt_data[0]) open_fnum_q <= pkt_data[23:8];
        end
    end

    a_r5_layout: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_data[31:30] == 2'b00) && (pkt_data[5:1] == 5'd0)
                      && (pkt_data[7:6] == VC_ID));

    a_r6_ecc: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> pkt_data[31:24] == col_ecc(pkt_data[23:0]));

    a_r4_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready) |-> pkt_data[0] == want_end_q);

    a_r7_same_fnum: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready && pkt_data[0]) |-> pkt_data[23:8] == open_fnum_q);

    a_r7_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> pkt_data[23:8] != 16'd0);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=> pkt_valid && $stable(pkt_data));

endmodule

bind fsp_frame_sync_gen fsp_frame_sync_gen_chk #(.VC_ID(VC_ID)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_valid (pkt_valid),
    .pkt_ready (pkt_ready),
    .pkt_data  (pkt_data)
);

// File: tb/fsp_frame_sync_gen_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: stimulus tasks queue expected words, a monitor pops on each handshake.
module fsp_frame_sync_gen_bench;

    localparam logic [1:0] VC = 2'd2;
    localparam int BASE = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fv = 1'b0;
    logic        ready = 1'b1;
    logic [7:0]  cfg = 8'd0;
    logic        pkt_valid;
    logic [31:0] pkt_data;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] exp_q[$];
    logic [15:0] exp_fnum = 16'd1;
    int          rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic        stall_prev = 1'b0;
    logic [31:0] stall_data = '0;

    always #2.5 clk = ~clk;

    fsp_frame_sync_gen #(.CNT_W(8), .MIN_BASE(BASE), .VC_ID(VC)) u_fsp_frame_sync_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .fv_in        (fv),
        .cfg_min_time (cfg),
        .pkt_valid    (pkt_valid),
        .pkt_ready    (ready),
        .pkt_data     (pkt_data)
    );

    localparam logic [5:0] CODE [24] = '{
        6'h07, 6'h0B, 6'h0D, 6'h0E, 6'h13, 6'h15, 6'h16, 6'h19,
        6'h1A, 6'h1C, 6'h23, 6'h25, 6'h26, 6'h29, 6'h2A, 6'h2C,
        6'h31, 6'h32, 6'h34, 6'h38, 6'h1F, 6'h2F, 6'h37, 6'h3B
    };

    function automatic logic [31:0] mk_word(input logic [5:0] dt, input logic [15:0] fn);
        logic [23:0] h;
        logic [5:0]  s;
        h = {fn, VC, dt};
        s = '0;
        for (int i = 0; i < 24; i++) if (h[i]) s ^= CODE[i];
        return {2'b00, s, h};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int thr();
        return int'(cfg) + BASE;
    endfunction

    task automatic expect_frame();
        exp_q.push_back(mk_word(6'h00, exp_fnum));
        exp_q.push_back(mk_word(6'h01, exp_fnum));
        exp_fnum = exp_fnum + 16'd1;
        if (exp_fnum == 16'd0) exp_fnum = 16'd1;
    endtask

    task automatic send_pulse(input int len, input int gap);
        if (len >= thr()) expect_frame();
        @(negedge clk) fv = 1'b1;
        repeat (len) @(negedge clk);
        fv = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, req, 32'(exp_q.size()), 32'd0);
    endtask

    // Ready driver: changes just after each rising edge.
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0: ready = 1'b1;
            1: ready = lfsr[0] | lfsr[1];
            default: ready = 1'b0;
        endcase
    end

    // Monitor: stall hold and in-order comparison against the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_prev) begin
                check(pkt_valid && (pkt_data == stall_data), "R8 hold during stall",
                      pkt_data, stall_data);
            end
            if (pkt_valid && ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected packet", pkt_data, 32'hxxxxxxxx);
                end else begin
                    check(pkt_data == exp_q[0], "R4 R5 R6 R7 packet word", pkt_data, exp_q[0]);
                    void'(exp_q.pop_front());
                end
            end
            stall_prev = pkt_valid && !ready;
            stall_data = pkt_data;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        // R1: reset state.
        repeat (4) @(negedge clk);
        check(pkt_valid == 1'b0, "R1 valid in reset", 32'(pkt_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pkt_valid == 1'b0, "R1 valid after reset", 32'(pkt_valid), 32'd0);

        // R2: frame-start latency with setting 0 (threshold 5).
        cfg = 8'd0;
        expect_frame();
        @(negedge clk) fv = 1'b1;
        n = 0;
        while (!pkt_valid && n < 60) begin
            @(negedge clk);
            n++;
        end
        check(n == thr() + 1, "R2 frame-start latency", 32'(n), 32'(thr() + 1));
        repeat (6) @(negedge clk);
        fv = 1'b0;
        n = 0;
        while (!pkt_valid && n < 60) begin
            @(negedge clk);
            n++;
        end
        check(n == 2, "R4 frame-end latency", 32'(n), 32'd2);
        repeat (20) @(negedge clk);

        // R2/R3 boundaries at threshold 5.
        send_pulse(thr(), 30);
        send_pulse(thr() - 1, 30);
        send_pulse(thr() - 1, 0);
        send_pulse(thr() - 1, 30);
        send_pulse(1, 30);
        drain("R3 short pulses ignored");

        // R2/R3 boundaries at threshold 8.
        cfg = 8'd3;
        send_pulse(thr() - 1, 30);
        send_pulse(thr(), 30);
        send_pulse(thr() - 1, 0);
        send_pulse(thr() - 1, 30);
        send_pulse(thr() + 17, 30);
        drain("R4 threshold 8 frames delivered");

        // R8: pseudo-random backpressure, line-free frames, threshold 25.
        cfg = 8'd20;
        rdy_mode = 1;
        for (int f = 0; f < 12; f++) begin
            send_pulse(thr() + (f * 3) % 11, 40);
            send_pulse(thr() - 1 - f % 3, 40);
        end
        rdy_mode = 0;
        drain("R8 random stall delivery");

        // R8: long stall spanning both frame-valid edges.
        cfg = 8'd0;
        rdy_mode = 2;
        @(negedge clk);
        @(negedge clk);
        send_pulse(thr() + 2, 10);
        repeat (30) @(negedge clk);
        check(pkt_valid && pkt_data == exp_q[0], "R8 held frame-start", pkt_data, exp_q[0]);
        rdy_mode = 0;
        drain("R8 held frame-end delivered");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule